// File: doc/BRIEF.md
# Register Init Script Sequencer

This block runs a short bring-up program without help from software. The program is a list of entries in a memory outside the block. Each entry holds a 16-bit register address and a 16-bit value. After a start pulse the sequencer reads the entries one by one, beginning at index 0. An ordinary entry becomes one write on a simple register bus: address, write data and a one-cycle strobe.

Three address codes at the top of the 16-bit space are control opcodes and do not become writes:

- **Stop** ends the program.
- **Pause** waits for a number of millisecond ticks.
- **Lock wait** holds until both PLL lock bits are set.

The lock wait has a limit in cycles. If the limit runs out, the sequencer raises an error flag and ends the program. The program also ends after the number of entries given with the start pulse.

The script memory is a synchronous read port. The block drives an index, and the memory returns the entry on the next cycle.

Top module: `script_seq`

## Requirements
- R1: An entry whose address is below 0xFFFD gives one bus write. The write is a single cycle with `bus_we_o` high, `bus_addr_o` equal to the entry address and `bus_wdata_o` equal to the entry value. Writes come out in entry order.
- R2: Address 0xFFFF ends the program at once. No later entry is written, and `done_o` pulses.
- R3: Address 0xFFFE waits for N pulses of `ms_tick_i`, where N is the entry value, before the next entry. Ticks that arrive while the sequencer is fetching or decoding do not count. With N = 0 the next entry is fetched in the next cycle, so two writes around it are 5 cycles apart.
- R4: Address 0xFFFD holds the program until `pll_lock_i` equals 2'b11. Lock bits of 2'b00, 2'b01 or 2'b10 keep it waiting. The value field has no effect.
- R5: If `script_len_i` is L (sampled at start), at most entries 0 to L-1 are processed and the program then ends. L = 0 ends the program without any write.
- R6: A start pulse while `busy_o` is high has no effect on the running program. No extra run follows it.
- R7: `done_o` is high for exactly one cycle per run. `busy_o` rises in the cycle after start is accepted, stays high up to and including the done cycle, and is low in the next cycle.
- R8: If lock is not seen during LOCK_TIMEOUT consecutive cycles of a lock wait, the program ends with `done_o`. `err_o` rises in that same cycle. `err_o` stays high until the next accepted start clears it.
- R9: If lock arrives in the last cycle of the timeout window, lock wins: the program continues and `err_o` stays low.
- R10: After reset `busy_o`, `done_o`, `err_o` and `bus_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| script_len_i | input | IDX_W+1 | Number of entries to process, sampled at start |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | One-cycle end-of-program pulse |
| err_o | output | 1 | Lock-wait timeout occurred in the last run |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| pll_lock_i | input | 2 | Lock status of the two PLLs |
| rom_idx_o | output | IDX_W | Entry index to the script memory |
| rom_entry_i | input | 32 | Entry read back, {address, value}, one cycle after the index |
| bus_addr_o | output | 16 | Register bus address |
| bus_wdata_o | output | 16 | Register bus write data |
| bus_we_o | output | 1 | Register bus write strobe |

## Verification
A lock wait can end in two ways: by lock or by timeout. These two can fall in the same cycle, when lock arrives in the very cycle the timeout window closes.

The bench counts cycles from the write strobe of the entry before the wait. It raises both lock bits exactly in that final window cycle in one run, and one cycle later in another run. The first run must continue with the following write and a clear error flag. The second must end early with the error flag raised.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int unsigned REG_W = 16;

  localparam logic [REG_W-1:0] OP_STOP  = 16'hFFFF;
  localparam logic [REG_W-1:0] OP_PAUSE = 16'hFFFE;
  localparam logic [REG_W-1:0] OP_LOCK  = 16'hFFFD;

  typedef struct packed {
    logic [REG_W-1:0] reg_addr;
    logic [REG_W-1:0] value;
  } entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_WRITE,
    ST_PAUSE,
    ST_LOCK,
    ST_FINISH
  } seq_state_e;

endpackage

// File: rtl/seq_ms_timer.sv
module seq_ms_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  assign expire_o = run_i && tick_i && (rem_q == CNT_W'(1));

  always_comb begin
    rem_en = 1'b0;
    rem_d  = rem_q;
    if (load_i) begin
      rem_en = 1'b1;
      rem_d  = load_val_i;
    end else if (run_i && tick_i && (rem_q != '0)) begin
      rem_en = 1'b1;
      rem_d  = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

endmodule

// File: rtl/seq_lock_watch.sv
module seq_lock_watch #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       run_i,
  input  logic [1:0] lock_bits_i,
  output logic       locked_o,
  output logic       expired_o
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign locked_o  = &lock_bits_i;
  // lock has priority over the closing window
  assign expired_o = run_i && !locked_o && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run_i && (cnt_q != LAST)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W:0]   len_i,
  input  entry_t           entry_i,
  input  logic             pause_done_i,
  input  logic             lock_ok_i,
  input  logic             lock_expired_i,
  output seq_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output entry_t           entry_o,
  output logic             err_o
);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W:0]   len_q, len_d;
  entry_t           ent_q, ent_d;
  logic             err_q, err_d;
  logic             advance;
  logic             is_last;
  logic             len_en, idx_en, ent_en, err_en;

  assign is_last = (({1'b0, idx_q} + (IDX_W+1)'(1)) == len_q);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    ent_d   = ent_q;
    err_d   = err_q;
    advance = 1'b0;
    len_en  = 1'b0;
    idx_en  = 1'b0;
    ent_en  = 1'b0;
    err_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          len_en  = 1'b1;
          len_d   = len_i;
          idx_en  = 1'b1;
          idx_d   = '0;
          err_en  = 1'b1;
          err_d   = 1'b0;
          state_d = (len_i == '0) ? ST_FINISH : ST_FETCH;
        end
      end
      ST_FETCH: state_d = ST_DECODE;
      ST_DECODE: begin
        ent_en = 1'b1;
        ent_d  = entry_i;
        if (entry_i.reg_addr == OP_STOP) begin
          state_d = ST_FINISH;
        end else if (entry_i.reg_addr == OP_PAUSE) begin
          if (entry_i.value == '0) advance = 1'b1;
          else                     state_d = ST_PAUSE;
        end else if (entry_i.reg_addr == OP_LOCK) begin
          state_d = ST_LOCK;
        end else begin
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: advance = 1'b1;
      ST_PAUSE: advance = pause_done_i;
      ST_LOCK: begin
        if (lock_ok_i) begin
          advance = 1'b1;
        end else if (lock_expired_i) begin
          err_en  = 1'b1;
          err_d   = 1'b1;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    if (advance) begin
      if (is_last) begin
        state_d = ST_FINISH;
      end else begin
        idx_en  = 1'b1;
        idx_d   = idx_q + IDX_W'(1);
        state_d = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= '0;
    else if (ent_en) ent_q <= ent_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign entry_o = ent_q;
  assign err_o   = err_q;

endmodule

// File: rtl/script_seq.sv
module script_seq
  import seq_pkg::*;
#(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned LOCK_TIMEOUT = 64,
  localparam int unsigned IDX_W       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W:0]   script_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  input  logic             ms_tick_i,
  input  logic [1:0]       pll_lock_i,
  output logic [IDX_W-1:0] rom_idx_o,
  input  logic [31:0]      rom_entry_i,
  output logic [15:0]      bus_addr_o,
  output logic [15:0]      bus_wdata_o,
  output logic             bus_we_o
);

  seq_state_e state;
  entry_t     ent_cur;
  entry_t     ent_rd;
  logic       pause_done;
  logic       lock_ok;
  logic       lock_exp;

  assign ent_rd = entry_t'(rom_entry_i);

  seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .len_i          (script_len_i),
    .entry_i        (ent_rd),
    .pause_done_i   (pause_done),
    .lock_ok_i      (lock_ok),
    .lock_expired_i (lock_exp),
    .state_o        (state),
    .idx_o          (rom_idx_o),
    .entry_o        (ent_cur),
    .err_o          (err_o)
  );

  seq_ms_timer #(.CNT_W(REG_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (state == ST_DECODE),
    .load_val_i (ent_rd.value),
    .run_i      (state == ST_PAUSE),
    .tick_i     (ms_tick_i),
    .expire_o   (pause_done)
  );

  seq_lock_watch #(.TIMEOUT(LOCK_TIMEOUT)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (state == ST_DECODE),
    .run_i       (state == ST_LOCK),
    .lock_bits_i (pll_lock_i),
    .locked_o    (lock_ok),
    .expired_o   (lock_exp)
  );

  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_FINISH);
  assign bus_we_o    = (state == ST_WRITE);
  assign bus_addr_o  = ent_cur.reg_addr;
  assign bus_wdata_o = ent_cur.value;

endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        bus_we_o,
  input logic [15:0] bus_addr_o
);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R1
  write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we_o |-> (bus_addr_o < 16'hFFFD));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_we_o);

  // R8
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past(start_i));

endmodule

bind script_seq seq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o)
);

// File: tb/sim_script_seq.sv
`timescale 1ns/1ps
module sim_script_seq;

  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam int TO    = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [IDX_W:0]    len_i = '0;
  logic              busy_o, done_o, err_o;
  logic              ms_tick = 1'b0;
  logic [1:0]        pll = 2'b11;
  logic [IDX_W-1:0]  rom_idx;
  logic [31:0]       rom_q;
  logic [15:0]       bus_addr, bus_wdata;
  logic              bus_we;

  logic [31:0] rom [0:DEPTH-1];

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int tick_total = 0;
  int cap_n = 0;
  int cap_addr [0:63];
  int cap_data [0:63];
  int cap_cyc  [0:63];
  int cap_tick [0:63];
  int done_cnt = 0;
  int done_long = 0;
  int busy_after = 0;
  bit prev_done = 0;
  int lock_plan = -1;
  int lock_target = -1;
  int exp_n;
  int exp_addr [0:63];
  int exp_data [0:63];

  always #4 clk = ~clk;

  always_ff @(posedge clk) rom_q <= rom[rom_idx];

  script_seq #(.DEPTH(DEPTH), .LOCK_TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .script_len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ms_tick_i(ms_tick),
    .pll_lock_i(pll), .rom_idx_o(rom_idx), .rom_entry_i(rom_q),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_we_o(bus_we)
  );

  // monitor, tick source and timed lock driver, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (bus_we && cap_n < 64) begin
      cap_addr[cap_n] = bus_addr;
      cap_data[cap_n] = bus_wdata;
      cap_cyc[cap_n]  = cyc;
      cap_tick[cap_n] = tick_total;
      cap_n++;
      if (lock_plan >= 0 && cap_n == 1) lock_target = cyc + lock_plan;
    end
    if (done_o) done_cnt++;
    if (done_o && prev_done) done_long++;
    if (prev_done && busy_o) busy_after++;
    prev_done = done_o;
    if (cyc == lock_target) pll = 2'b11;
    ms_tick = ((cyc % 10) == 9);
    if (ms_tick) tick_total++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wr(input int a, input int d);
    return {a[15:0], d[15:0]};
  endfunction

  task automatic build_expected(input int len);
    exp_n = 0;
    for (int i = 0; i < len; i++) begin
      if (rom[i][31:16] == 16'hFFFF) break;
      if (rom[i][31:16] < 16'hFFFD) begin
        exp_addr[exp_n] = rom[i][31:16];
        exp_data[exp_n] = rom[i][15:0];
        exp_n++;
      end
    end
  endtask

  task automatic run(input int len, input bit restart_mid);
    int guard;
    cap_n = 0;
    done_cnt = 0;
    @(negedge clk);
    len_i = len[IDX_W:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    guard = 0;
    while (done_cnt == 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (restart_mid && guard == 4) start_i = 1'b1;
      if (restart_mid && guard == 5) start_i = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic compare_writes(input string req);
    bit ok = (cap_n == exp_n);
    chk(ok, {req, " write count"}, cap_n, exp_n);
    if (ok) begin
      for (int i = 0; i < exp_n; i++) begin
        if (cap_addr[i] != exp_addr[i] || cap_data[i] != exp_data[i]) begin
          chk(0, {req, " write content"}, cap_addr[i], exp_addr[i]);
          return;
        end
      end
      chk(1, {req, " write content"}, 0, 0);
    end
  endtask

  task automatic fill_writes();
    for (int i = 0; i < DEPTH; i++) rom[i] = wr(16'h0100 + i, 16'h5A00 + i);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int len;
    int r;
    void'($urandom(32'd1234));
    fill_writes();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy_o, done_o, err_o, bus_we} == 4'b0, "R10 reset outputs",
        {busy_o, done_o, err_o, bus_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy_o, done_o, err_o, bus_we} == 4'b0, "R10 after release",
        {busy_o, done_o, err_o, bus_we}, 0);

    // R1 R2 R5 random scripts checked against the bench model
    for (int run_i = 0; run_i < 20; run_i++) begin
      for (int i = 0; i < DEPTH; i++) begin
        r = $urandom % 10;
        if (r == 0)                          rom[i] = wr(16'hFFFE, $urandom % 4);
        else if (r == 1)                     rom[i] = wr(16'hFFFD, $urandom);
        else if (r == 2 && ($urandom % 3 == 0)) rom[i] = wr(16'hFFFF, $urandom);
        else                                 rom[i] = wr($urandom % 16'hFFFD, $urandom);
      end
      len = 1 + ($urandom % DEPTH);
      pll = 2'b11;
      build_expected(len);
      run(len, 1'b0);
      compare_writes("R1 random");
      chk(done_cnt == 1, "R7 one done per run", done_cnt, 1);
      chk(err_o == 1'b0, "R8 no error when locked", err_o, 0);
    end

    // R2 stop code
    fill_writes();
    rom[1] = wr(16'hFFFF, 16'h0000);
    build_expected(3);
    run(3, 1'b0);
    chk(cap_n == 1 && cap_addr[0] == 16'h0100, "R2 stop code", cap_n, 1);

    // R5 length limit, including zero length
    fill_writes();
    run(2, 1'b0);
    chk(cap_n == 2 && cap_addr[1] == 16'h0101, "R5 length limit", cap_n, 2);
    run(0, 1'b0);
    chk(cap_n == 0 && done_cnt == 1, "R5 zero length", cap_n, 0);

    // R3 zero pause: writes 5 cycles apart
    fill_writes();
    rom[1] = wr(16'hFFFE, 0);
    run(3, 1'b0);
    chk(cap_n == 2 && (cap_cyc[1] - cap_cyc[0]) == 5, "R3 zero pause gap",
        cap_cyc[1] - cap_cyc[0], 5);

    // R3 pause of 3 ticks
    rom[1] = wr(16'hFFFE, 3);
    run(3, 1'b0);
    chk(cap_n == 2 && (cap_tick[1] - cap_tick[0]) >= 3 && (cap_tick[1] - cap_tick[0]) <= 4,
        "R3 pause ticks", cap_tick[1] - cap_tick[0], 3);

    // R4 lock wait: partial lock holds, value ignored
    fill_writes();
    rom[1] = wr(16'hFFFD, 16'h1234);
    pll = 2'b10;
    cap_n = 0;
    done_cnt = 0;
    len_i = 3;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(cap_n == 1, "R4 hold on lock bits 10", cap_n, 1);
    pll = 2'b01;
    repeat (3) @(negedge clk);
    chk(cap_n == 1, "R4 hold on lock bits 01", cap_n, 1);
    pll = 2'b11;
    repeat (12) @(negedge clk);
    chk(cap_n == 2 && cap_addr[1] == 16'h0102 && err_o == 1'b0, "R4 resume on lock",
        cap_n, 2);

    // R8 timeout: error and early end, sticky until restart
    pll = 2'b00;
    run(3, 1'b0);
    chk(cap_n == 1 && done_cnt == 1, "R8 timeout ends run", cap_n, 1);
    chk(err_o == 1'b1, "R8 error raised", err_o, 1);
    repeat (5) @(negedge clk);
    chk(err_o == 1'b1, "R8 error held", err_o, 1);
    pll = 2'b11;
    run(3, 1'b0);
    chk(err_o == 1'b0 && cap_n == 2, "R8 error cleared by start", err_o, 0);

    // R9 lock in last window cycle wins
    pll = 2'b00;
    lock_plan = TO + 2;
    lock_target = -1;
    run(3, 1'b0);
    chk(err_o == 1'b0 && cap_n == 2, "R9 lock at expiry wins", {err_o, 4'(cap_n)}, 2);
    pll = 2'b00;
    lock_plan = TO + 3;
    lock_target = -1;
    run(3, 1'b0);
    chk(err_o == 1'b1 && cap_n == 1, "R8 lock one cycle late", {err_o, 4'(cap_n)}, 17);
    lock_plan = -1;
    lock_target = -1;
    pll = 2'b11;

    // R6 start during busy is ignored
    fill_writes();
    rom[1] = wr(16'hFFFE, 2);
    build_expected(4);
    run(4, 1'b1);
    compare_writes("R6 restart ignored");
    chk(done_cnt == 1, "R6 single done", done_cnt, 1);

    // R7 done width and busy release
    chk(done_long == 0, "R7 done one cycle", done_long, 0);
    chk(busy_after == 0, "R7 busy low after done", busy_after, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule